// File: doc/BRIEF.md
# Lane-Partitioned Vector Add/Compare Unit

This unit treats each 64-bit operand word as a packed vector of equal-width integer lanes and runs one arithmetic or comparison function on every lane at once. A six-bit operation code chooses the lane width (8, 16 or 32 bits), whether the lanes are read as two's-complement or unsigned numbers, whether add and subtract results clip to the lane's range or wrap modulo 2^w, and which function runs: add, subtract, greater-than or greater-or-equal.

One byte-sliced carry chain serves every lane width. A carry is cut at each lane boundary, and the lane's top byte supplies the carry, sign and overflow facts that decide clipping and comparison. Operands enter with a valid flag. The result and its delayed flag leave two clock edges later, and a new operation can be accepted on every cycle.

Top module: `simd_valu`

## Requirements
- R1: A result appears exactly two rising edges after its operands are accepted. `out_valid` repeats `in_valid` with a delay of two cycles, and one operation can be issued per cycle.
- R2: The opcode fields are laid out as follows. `in_op[1:0]` is the lane width: 00 gives 8-bit lanes, 01 gives 16-bit lanes, and 10 or 11 give 32-bit lanes. `in_op[2]` set means the lanes are signed. `in_op[3]` set means add and subtract saturate. `in_op[5:4]` is the function: 00 add, 01 subtract, 10 greater-than, 11 greater-or-equal. With saturation off, an add gives each lane (a+b) mod 2^w, and no carry crosses into the next lane.
- R3: With saturation off, a subtract gives each lane (a−b) mod 2^w, and no borrow crosses into the next lane.
- R4: An unsigned saturating add clamps a lane at 2^w−1. An unsigned saturating subtract clamps a lane at 0.
- R5: A signed saturating add or subtract clamps a lane at 2^(w−1)−1 on positive overflow and at −2^(w−1) on negative overflow.
- R6: Greater-than writes all ones into a lane when a > b under the selected signedness, and all zeros otherwise. The saturate bit has no effect on it.
- R7: Greater-or-equal writes all ones into a lane when a ≥ b under the selected signedness, and all zeros otherwise.
- R8: While `rst` is high, `out_valid` and `out_result` are cleared to zero on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| in_op | input | 6 | Function, saturate, signed and lane-width fields |
| in_a | input | 64 | First source vector |
| in_b | input | 64 | Second source vector |
| out_valid | output | 1 | `in_valid` delayed by two cycles |
| out_result | output | 64 | Packed lane results |

## Verification
The bench first runs a sweep over every opcode with operands built from boundary bytes (00, 01, 7F, 80, FE, FF). It then runs an exhaustive 256×256 pair sweep in 8-bit lanes for the signed and unsigned clip and compare cases. A design that leaks carries across lanes corrupts the lane above an all-ones byte. A design that takes the wrong overflow test clips signed sums to the unsigned limits, or misses the 80h−01h edge. A design that compares with the wrong sign rule ranks 80h above 7Fh in signed mode. Ties (a = b) expose greater-than being confused with greater-or-equal, and the valid flag is checked on every cycle for a one-cycle or three-cycle latency.

// File: rtl/simd_valu_pkg.sv
package simd_valu_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LW_8   = 2'b00,
        LW_16  = 2'b01,
        LW_32  = 2'b10,
        LW_32B = 2'b11
    } lane_w_e;

    typedef enum logic [1:0] {
        FN_ADD = 2'b00,
        FN_SUB = 2'b01,
        FN_GTR = 2'b10,
        FN_GEQ = 2'b11
    } func_e;

    typedef struct packed {
        func_e   func;
        logic    sat;
        logic    sgn;
        lane_w_e width;
    } vop_t;

    localparam int OP_W = $bits(vop_t);

    // low byte-index bits that stay inside one lane
    function automatic logic [1:0] lane_mask(lane_w_e w);
        case (w)
            LW_8:    return 2'b00;
            LW_16:   return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic uses_sub(func_e f);
        return f != FN_ADD;
    endfunction

endpackage

// File: rtl/simd_part_adder.sv
module simd_part_adder
    import simd_valu_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic [NB*BYTE_W-1:0] a_i,
    input  logic [NB*BYTE_W-1:0] b_i,
    input  lane_w_e              width_i,
    input  logic                 sub_i,
    output logic [NB*BYTE_W-1:0] sum_o,
    output logic [NB*BYTE_W-1:0] bx_o,
    output logic [NB-1:0]        cout_o
);
    logic [1:0] mask;
    assign mask = lane_mask(width_i);
    assign bx_o = sub_i ? ~b_i : b_i;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic       cin;
        logic [8:0] s9;
        if (g == 0) begin : g_first
            assign cin = sub_i;
        end else begin : g_rest
            // a lane boundary restarts the chain with the subtract carry-in
            assign cin = ((2'(g) & mask) == 2'b00) ? sub_i : cout_o[g-1];
        end
        assign s9 = {1'b0, a_i[g*BYTE_W +: BYTE_W]} + {1'b0, bx_o[g*BYTE_W +: BYTE_W]} + 9'(cin);
        assign sum_o[g*BYTE_W +: BYTE_W] = s9[7:0];
        assign cout_o[g] = s9[8];
    end
endmodule

// File: rtl/simd_lane_post.sv
module simd_lane_post
    import simd_valu_pkg::*;
#(
    parameter int NB = 8
) (
    input  logic [NB*BYTE_W-1:0] sum_i,
    input  logic [NB-1:0]        cout_i,
    input  logic [NB-1:0]        amsb_i,
    input  logic [NB-1:0]        bmsb_i,
    input  vop_t                 op_i,
    output logic [NB*BYTE_W-1:0] res_o
);
    logic [NB-1:0] bz;

    for (genvar g = 0; g < NB; g++) begin : g_zero
        assign bz[g] = (sum_i[g*BYTE_W +: BYTE_W] == '0);
    end

    for (genvar g = 0; g < NB; g++) begin : g_byte
        localparam int T16 = g | 1;
        localparam int T32 = g | 3;
        localparam int L16 = g & ~1;
        localparam int L32 = g & ~3;

        logic       c, am, bm, sm, z, top;
        logic       ovf, ge, gt;
        logic [7:0] ob;

        always_comb begin
            case (op_i.width)
                LW_8: begin
                    c = cout_i[g]; am = amsb_i[g]; bm = bmsb_i[g];
                    sm = sum_i[g*BYTE_W+7]; z = bz[g]; top = 1'b1;
                end
                LW_16: begin
                    c = cout_i[T16]; am = amsb_i[T16]; bm = bmsb_i[T16];
                    sm = sum_i[T16*BYTE_W+7]; z = &bz[L16+1:L16]; top = (g == T16);
                end
                default: begin
                    c = cout_i[T32]; am = amsb_i[T32]; bm = bmsb_i[T32];
                    sm = sum_i[T32*BYTE_W+7]; z = &bz[L32+3:L32]; top = (g == T32);
                end
            endcase

            ovf = (am == bm) && (sm != am);
            ge  = op_i.sgn ? ~(sm ^ ovf) : c;
            gt  = ge & ~z;

            case (op_i.func)
                FN_GTR: ob = {8{gt}};
                FN_GEQ: ob = {8{ge}};
                default: begin
                    ob = sum_i[g*BYTE_W +: BYTE_W];
                    if (op_i.sat) begin
                        if (!op_i.sgn && op_i.func == FN_ADD && c) begin
                            ob = 8'hFF;
                        end else if (!op_i.sgn && op_i.func == FN_SUB && !c) begin
                            ob = 8'h00;
                        end else if (op_i.sgn && ovf) begin
                            if (am) ob = top ? 8'h80 : 8'h00;
                            else    ob = top ? 8'h7F : 8'hFF;
                        end
                    end
                end
            endcase
        end

        assign res_o[g*BYTE_W +: BYTE_W] = ob;
    end
endmodule

// File: rtl/simd_valu.sv
module simd_valu
    import simd_valu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   in_op,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result
);
    localparam int NB = DATA_W / BYTE_W;

    vop_t            op_in;
    logic [DATA_W-1:0] sum_c, bx_c, res_c;
    logic [NB-1:0]     cout_c, amsb_c, bmsb_c;

    assign op_in = vop_t'(in_op);

    simd_part_adder #(.NB(NB)) u_add (
        .a_i     (in_a),
        .b_i     (in_b),
        .width_i (op_in.width),
        .sub_i   (uses_sub(op_in.func)),
        .sum_o   (sum_c),
        .bx_o    (bx_c),
        .cout_o  (cout_c)
    );

    for (genvar g = 0; g < NB; g++) begin : g_msb
        assign amsb_c[g] = in_a[g*BYTE_W+7];
        assign bmsb_c[g] = bx_c[g*BYTE_W+7];
    end

    // stage 1: raw partitioned sum and per-byte flags
    logic [DATA_W-1:0] s1_sum;
    logic [NB-1:0]     s1_cout, s1_amsb, s1_bmsb;
    vop_t              s1_op;
    logic              s1_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_sum   <= '0;
            s1_cout  <= '0;
            s1_amsb  <= '0;
            s1_bmsb  <= '0;
            s1_op    <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sum   <= sum_c;
            s1_cout  <= cout_c;
            s1_amsb  <= amsb_c;
            s1_bmsb  <= bmsb_c;
            s1_op    <= op_in;
        end
    end

    simd_lane_post #(.NB(NB)) u_post (
        .sum_i  (s1_sum),
        .cout_i (s1_cout),
        .amsb_i (s1_amsb),
        .bmsb_i (s1_bmsb),
        .op_i   (s1_op),
        .res_o  (res_c)
    );

    // stage 2: clipped or compared result
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= s1_valid;
            out_result <= res_c;
        end
    end
endmodule

// File: rtl/simd_valu_chk.sv
module simd_valu_chk
    import simd_valu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   in_op,
    input logic [DATA_W-1:0] in_a,
    input logic [DATA_W-1:0] in_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result
);
    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (rst) cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r2_add8_wrap: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(in_valid, 2) && $past(in_op, 2) == 6'b00_0_0_00)
        |-> (out_result[7:0] == 8'($past(in_a[7:0], 2) + $past(in_b[7:0], 2))));

    a_r4_usat_add_floor: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(in_valid, 2) && $past(in_op, 2) == 6'b00_1_0_00)
        |-> (out_result[7:0] >= $past(in_a[7:0], 2)));

    a_r6_cmp_full_lane: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(in_valid, 2) && $past(in_op[5], 2) && $past(in_op[1:0], 2) == 2'b00)
        |-> ((out_result[7:0] == 8'h00 || out_result[7:0] == 8'hFF) &&
             (out_result[DATA_W-1 -: 8] == 8'h00 || out_result[DATA_W-1 -: 8] == 8'hFF)));

    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (!out_valid && out_result == '0));
endmodule

bind simd_valu simd_valu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_a       (in_a),
    .in_b       (in_b),
    .out_valid  (out_valid),
    .out_result (out_result)
);

// File: tb/simd_valu_tb_top.sv
module simd_valu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [5:0]  in_op = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;

    always #5 clk = ~clk;

    simd_valu #(.DATA_W(64)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_a       (in_a),
        .in_b       (in_b),
        .out_valid  (out_valid),
        .out_result (out_result)
    );

    logic [63:0] q_exp[$];
    logic [63:0] q_a[$];
    logic [63:0] q_b[$];
    logic [5:0]  q_op[$];
    int n_vec = 0;
    int n_bad = 0;
    logic v1 = 1'b0, v2 = 1'b0;

    function automatic string req_tag(logic [5:0] op);
        case (op[5:4])
            2'd0:    return op[3] ? (op[2] ? "R5" : "R4") : "R2";
            2'd1:    return op[3] ? (op[2] ? "R5" : "R4") : "R3";
            2'd2:    return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [5:0] op);
        int w;
        logic [63:0] r;
        w = (op[1:0] == 2'd0) ? 8 : (op[1:0] == 2'd1) ? 16 : 32;
        r = '0;
        for (int l = 0; l < 64 / w; l++) begin
            longint m, x, y, z, hi, lo;
            m = (longint'(1) << w) - 1;
            x = longint'(a >> (l * w)) & m;
            y = longint'(b >> (l * w)) & m;
            if (op[2]) begin
                if (x >= (longint'(1) << (w - 1))) x = x - (longint'(1) << w);
                if (y >= (longint'(1) << (w - 1))) y = y - (longint'(1) << w);
            end
            case (op[5:4])
                2'd0:    z = x + y;
                2'd1:    z = x - y;
                2'd2:    z = (x > y) ? m : 0;
                default: z = (x >= y) ? m : 0;
            endcase
            if (!op[5] && op[3]) begin
                hi = op[2] ? (longint'(1) << (w - 1)) - 1 : m;
                lo = op[2] ? -(longint'(1) << (w - 1)) : 0;
                if (z > hi) z = hi;
                if (z < lo) z = lo;
            end
            r = r | (64'(z & m) << (l * w));
        end
        return r;
    endfunction

    function automatic logic [63:0] pick();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) begin
            logic [7:0] bt;
            case ($urandom % 8)
                0:       bt = 8'h00;
                1:       bt = 8'h01;
                2:       bt = 8'h7F;
                3:       bt = 8'h80;
                4:       bt = 8'hFE;
                5:       bt = 8'hFF;
                default: bt = 8'($urandom);
            endcase
            v[k*8 +: 8] = bt;
        end
        return v;
    endfunction

    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [5:0] op);
        @(negedge clk);
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        in_op = op;
        q_exp.push_back(model(a, b, op));
        q_a.push_back(a);
        q_b.push_back(b);
        q_op.push_back(op);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // output monitor: samples 2 ns after each rising edge
    always @(posedge clk) begin
        v2 = v1;
        v1 = in_valid & ~rst;
        #2;
        if (!rst) begin
            if (out_valid !== v2) begin
                n_vec++; n_bad++;
                $display("FAIL R1 out_valid=%b expected=%b", out_valid, v2);
            end
            if (out_valid === 1'b1) begin
                n_vec++;
                if (q_exp.size() == 0) begin
                    n_bad++;
                    $display("FAIL R1 unexpected result %h expected none", out_result);
                end else begin
                    logic [63:0] e, a, b;
                    logic [5:0]  op;
                    e = q_exp.pop_front(); a = q_a.pop_front();
                    b = q_b.pop_front();   op = q_op.pop_front();
                    if (out_result !== e) begin
                        n_bad++;
                        $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                                 req_tag(op), op, a, b, out_result, e);
                    end
                end
            end
        end
    end

    initial begin
        #1_900_000;
        n_bad++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || out_result !== 64'h0) begin
            n_bad++;
            $display("FAIL R8 actual=%b/%h expected=0/0", out_valid, out_result);
        end
        rst = 1'b0;

        // directed carry-isolation cases (R2, R3)
        apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 6'b00_0_0_00);
        apply(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 6'b00_0_0_01);
        apply(64'h0100_0000_0000_0000, 64'h0000_0000_0000_0001, 6'b01_0_0_10);
        apply(64'h7F80_7F80_7F80_7F80, 64'h7F80_7F80_7F80_7F80, 6'b10_0_1_00);

        // every opcode with boundary-heavy operands (R2..R7)
        for (int f = 0; f < 4; f++)
            for (int s = 0; s < 2; s++)
                for (int g = 0; g < 2; g++)
                    for (int w = 0; w < 4; w++)
                        for (int k = 0; k < 120; k++)
                            apply(pick(), (k % 9 == 0) ? 64'h0 : pick(),
                                  {2'(f), 1'(s), 1'(g), 2'(w)});

        // exhaustive 8-bit pairs for clip and compare (R4, R5, R6, R7)
        for (int o = 0; o < 4; o++) begin
            logic [5:0] op;
            case (o)
                0:       op = 6'b00_1_0_00;
                1:       op = 6'b01_1_1_00;
                2:       op = 6'b10_0_1_00;
                default: op = 6'b11_0_0_00;
            endcase
            for (int i = 0; i < 256; i++)
                for (int j = 0; j < 32; j++) begin
                    logic [63:0] a, b;
                    for (int k = 0; k < 8; k++) begin
                        a[k*8 +: 8] = 8'(i);
                        b[k*8 +: 8] = 8'(j * 8 + k);
                    end
                    apply(a, b, op);
                end
        end

        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        n_vec++;
        if (q_exp.size() != 0) begin
            n_bad++;
            $display("FAIL R1 pending=%0d expected=0", q_exp.size());
        end
        summary();
        $finish;
    end
endmodule